// File: doc/BRIEF.md
# Dual-Line Masked Interrupt Aggregator

This block collects fifteen hardware event sources into two independent, level-sensitive interrupt outputs. Thirteen of the sources arrive as one-cycle strobes. The other two arrive as per-buffer status vectors, and each vector is reduced to a single event bit by an OR. Every interrupt line has its own bank of state with the same bit layout: an enable mask and a raw status word. The enabled status view of a line is raw status AND enable, and the line asserts whenever that view is non-zero. Because the masks are independent, software can steer one class of events (for example buffer errors) to one line and another class (for example memory-error thresholds) to the other line. It can also route an event to both lines or to neither.

Software reaches the state through a single-cycle register port. A write takes effect at the clock edge on which it is presented. Reads are combinational. Every write port is write-one-to-act, so writing 0 bits changes nothing. Software can also force raw status bits to 1. This injects an interrupt when the matching enable is set, which is useful for testing handlers.

Event bit layout, shared by both lines: bit 14 short frame (OR of the short-frame vector), bit 13 underflow (OR of the underflow vector), bit 12 overflow at wrap, bit 11 overflow at mid, bit 10 read sequence, bit 9 read start, bit 8 read out of range, bit 7 write sequence, bit 6 write start, bit 5 write out of range, bit 4 virtual address, bit 3 illegal buffer address, bit 2 address-error threshold, bit 1 double-error threshold, bit 0 single-error threshold. Strobe input bit k drives event bit k for k = 0..12.

Top module: `irq_dual_agg`

## Requirements
- R1: After reset, every enable bit, every raw status bit and both interrupt outputs are 0.
- R2: A write to register select 0 (address bits [1:0] = 0, address bit 2 = line) sets each enable bit of that line whose write-data bit is 1. A read of select 0 returns the line's enable mask.
- R3: A write to register select 1 clears each enable bit of that line whose write-data bit is 1.
- R4: An event sets its raw status bit in both lines on the next clock edge, whether or not it is enabled. A read of select 2 returns the line's raw status.
- R5: Reads of select 1 and of select 3 both return the enabled view, which is raw AND enable for that line.
- R6: A write to select 3 clears each raw status bit of that line whose write-data bit is 1, even when that event is disabled.
- R7: A write to select 2 forces each raw status bit whose write-data bit is 1 to 1. The line's interrupt then asserts if that bit is enabled.
- R8: Each interrupt output is a registered active-high level. After each clock edge it equals the OR of the line's raw AND enable.
- R9: The two lines are independent. One event asserts neither line, one line, or both, according to each line's own mask.
- R10: Event bit 14 is set when any bit of the short-frame vector is 1. Event bit 13 is set when any bit of the underflow vector is 1.
- R11: Write-data bits that are 0 change nothing in the addressed register, and the other line is never touched.
- R12: When a hardware event and a status-clear write hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_strobe | input | 13 | One-cycle event strobes for event bits 12..0 |
| short_frame_vec | input | NUM_BUF | Per-buffer short-frame status levels |
| underflow_vec | input | NUM_BUF | Per-buffer underflow status levels |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 3 | Bit 2 selects the line, bits 1:0 select the register |
| reg_wdata | input | 15 | Write data, one bit per event |
| reg_rdata | output | 15 | Combinational read data for reg_addr |
| irq_o | output | 2 | Interrupt level, one per line |

## Verification
The assertions check on every cycle that an event always leaves its raw bit set, including when a clear hits the same cycle. They also check that a clear without a competing event empties the bit, that all-zero writes leave the enable mask unchanged, that an enable-clear write removes the enable, and that each interrupt output matches raw AND enable. Only the bench scenarios show the steering of each of the fifteen events to one line or the other, the OR reduction of the per-buffer vectors, the read-back mapping of the four register selects, and forced injection through the raw-set register.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    localparam int NUM_EVT    = 15;
    localparam int NUM_STROBE = NUM_EVT - 2;
    localparam int BIT_SHORT  = 14;
    localparam int BIT_UNDER  = 13;

    typedef enum logic [1:0] {
        SEL_EN_SET   = 2'd0,
        SEL_EN_CLR   = 2'd1,
        SEL_RAW_SET  = 2'd2,
        SEL_STAT_CLR = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_EVT-1:0] en;
        logic [NUM_EVT-1:0] raw;
        logic               irq;
    } bank_state_t;
endpackage

// File: rtl/irq_agg_evt_merge.sv
module irq_agg_evt_merge
    import irq_agg_pkg::*;
#(
    parameter int NUM_BUF = 4
) (
    input  logic [NUM_STROBE-1:0] strobe,
    input  logic [NUM_BUF-1:0]    sf_vec,
    input  logic [NUM_BUF-1:0]    uf_vec,
    output logic [NUM_EVT-1:0]    evt
);
    always_comb begin
        evt                 = '0;
        evt[NUM_STROBE-1:0] = strobe;
        evt[BIT_SHORT]      = |sf_vec;
        evt[BIT_UNDER]      = |uf_vec;
    end
endmodule

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
    import irq_agg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt,
    input  logic               wr_en_set,
    input  logic               wr_en_clr,
    input  logic               wr_raw_set,
    input  logic               wr_stat_clr,
    input  logic [NUM_EVT-1:0] wdata,
    output logic [NUM_EVT-1:0] en_o,
    output logic [NUM_EVT-1:0] raw_o,
    output logic               irq_o
);
    bank_state_t st_d, st_q;

    always_comb begin
        logic [NUM_EVT-1:0] set_m, clr_m, force_m, wipe_m;
        set_m   = wr_en_set   ? wdata : '0;
        clr_m   = wr_en_clr   ? wdata : '0;
        force_m = wr_raw_set  ? wdata : '0;
        wipe_m  = wr_stat_clr ? wdata : '0;
        st_d     = st_q;
        st_d.en  = (st_q.en | set_m) & ~clr_m;
        st_d.raw = ((st_q.raw | force_m) & ~wipe_m) | evt;
        st_d.irq = |(st_d.raw & st_d.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o  = st_q.en;
    assign raw_o = st_q.raw;
    assign irq_o = st_q.irq;

    assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(raw_o & en_o));

    assert_zero_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wdata == '0) |=> $stable(en_o));

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_bit_chk
        assert_event_wins_R12: assert property (@(posedge clk) disable iff (!rst_n)
            evt[i] |=> raw_o[i]);
        assert_stat_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stat_clr && wdata[i] && !evt[i]) |=> !raw_o[i]);
        assert_en_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_clr && wdata[i]) |=> !en_o[i]);
    end
endmodule

// File: rtl/irq_dual_agg.sv
module irq_dual_agg
    import irq_agg_pkg::*;
#(
    parameter int NUM_BUF   = 4,
    parameter int NUM_LINES = 2,
    localparam int LINE_W   = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
    localparam int ADDR_W   = LINE_W + 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STROBE-1:0] evt_strobe,
    input  logic [NUM_BUF-1:0]    short_frame_vec,
    input  logic [NUM_BUF-1:0]    underflow_vec,
    input  logic                  reg_wr_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [NUM_EVT-1:0]    reg_wdata,
    output logic [NUM_EVT-1:0]    reg_rdata,
    output logic [NUM_LINES-1:0]  irq_o
);
    logic [NUM_EVT-1:0] evt;
    logic [NUM_EVT-1:0] en_w  [NUM_LINES];
    logic [NUM_EVT-1:0] raw_w [NUM_LINES];
    logic [LINE_W-1:0]  line_sel;
    reg_sel_e           reg_sel;

    assign line_sel = reg_addr[ADDR_W-1:2];
    assign reg_sel  = reg_sel_e'(reg_addr[1:0]);

    irq_agg_evt_merge #(.NUM_BUF(NUM_BUF)) u_merge (
        .strobe (evt_strobe),
        .sf_vec (short_frame_vec),
        .uf_vec (underflow_vec),
        .evt    (evt)
    );

    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
        logic hit;
        assign hit = reg_wr_en && (line_sel == LINE_W'(l));
        irq_agg_bank u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt         (evt),
            .wr_en_set   (hit && reg_sel == SEL_EN_SET),
            .wr_en_clr   (hit && reg_sel == SEL_EN_CLR),
            .wr_raw_set  (hit && reg_sel == SEL_RAW_SET),
            .wr_stat_clr (hit && reg_sel == SEL_STAT_CLR),
            .wdata       (reg_wdata),
            .en_o        (en_w[l]),
            .raw_o       (raw_w[l]),
            .irq_o       (irq_o[l])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int l = 0; l < NUM_LINES; l++) begin
            if (line_sel == LINE_W'(l)) begin
                case (reg_sel)
                    SEL_EN_SET:  reg_rdata = en_w[l];
                    SEL_RAW_SET: reg_rdata = raw_w[l];
                    default:     reg_rdata = raw_w[l] & en_w[l];
                endcase
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (irq_o == '0));
endmodule

// File: tb/test_irq_dual_agg.sv
module test_irq_dual_agg;
    localparam int CLK_PERIOD = 10;
    localparam int NB  = 4;
    localparam int NE  = 15;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [12:0]   evt_strobe = '0;
    logic [NB-1:0] short_frame_vec = '0;
    logic [NB-1:0] underflow_vec = '0;
    logic          reg_wr_en = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [NE-1:0] reg_wdata = '0;
    logic [NE-1:0] reg_rdata;
    logic [1:0]    irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [NE-1:0] m_en  [2];
    logic [NE-1:0] m_raw [2];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_dual_agg #(.NUM_BUF(NB)) i_irq_dual_agg (
        .clk, .rst_n, .evt_strobe, .short_frame_vec, .underflow_vec,
        .reg_wr_en, .reg_addr, .reg_wdata, .reg_rdata, .irq_o
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int line, input int sel, input logic [NE-1:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = {line[0], sel[1:0]}; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0;
        case (sel)
            0: m_en[line]  = m_en[line] | d;
            1: m_en[line]  = m_en[line] & ~d;
            2: m_raw[line] = m_raw[line] | d;
            default: m_raw[line] = m_raw[line] & ~d;
        endcase
    endtask

    task automatic rd(input int line, input int sel, output logic [NE-1:0] v);
        reg_addr = {line[0], sel[1:0]};
        #1 v = reg_rdata;
    endtask

    task automatic fire(input int b);
        @(negedge clk);
        if (b == 14)      short_frame_vec = NB'(1) << (b % NB);
        else if (b == 13) underflow_vec   = NB'(1) << (b % NB);
        else              evt_strobe      = 13'(1) << b;
        @(negedge clk);
        short_frame_vec = '0; underflow_vec = '0; evt_strobe = '0;
        m_raw[0][b] = 1'b1; m_raw[1][b] = 1'b1;
    endtask

    function automatic logic [1:0] exp_irq();
        return {|(m_raw[1] & m_en[1]), |(m_raw[0] & m_en[0])};
    endfunction

    task automatic check_all(input string req);
        logic [NE-1:0] v;
        for (int l = 0; l < 2; l++) begin
            rd(l, 0, v); chk({req, " R2 en"}, v, m_en[l]);
            rd(l, 2, v); chk({req, " R4 raw"}, v, m_raw[l]);
            rd(l, 1, v); chk({req, " R5 view1"}, v, m_raw[l] & m_en[l]);
            rd(l, 3, v); chk({req, " R5 view3"}, v, m_raw[l] & m_en[l]);
        end
        chk({req, " R8 irq"}, irq_o, exp_irq());
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NE-1:0] v;
        for (int l = 0; l < 2; l++) begin m_en[l] = '0; m_raw[l] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 reset");

        // R4 R9 R10 sweep: every event steered to one line, then the other
        for (int b = 0; b < NE; b++) begin
            int ln = b % 2;
            fire(b);
            check_all("R4 R10 event no enable");
            chk("R9 no line", irq_o, 2'b00);
            wr(ln, 0, NE'(1) << b);
            check_all("R2 R9 one line");
            chk("R9 steered", irq_o, 2'(1) << ln);
            wr(1 - ln, 0, NE'(1) << b);
            chk("R9 both lines", irq_o, 2'b11);
            wr(ln, 3, '0);
            check_all("R11 zero clear");
            wr(1 - ln, 1, NE'(1) << b);
            check_all("R3 disable");
            wr(1 - ln, 3, NE'(1) << b);
            check_all("R6 clear disabled");
            wr(ln, 3, NE'(1) << b);
            check_all("R6 clear enabled");
            chk("R8 idle", irq_o, 2'b00);
            wr(ln, 1, NE'(1) << b);
        end

        // R10 every buffer of both vectors
        for (int k = 0; k < NB; k++) begin
            @(negedge clk);
            short_frame_vec = NB'(1) << k;
            underflow_vec   = NB'(1) << ((k + 1) % NB);
            @(negedge clk);
            short_frame_vec = '0; underflow_vec = '0;
            rd(0, 2, v);
            chk("R10 vector reduce", v, 15'h6000);
            wr(0, 3, 15'h6000); wr(1, 3, 15'h6000);
            m_raw[0] = '0; m_raw[1] = '0;
        end

        // R7 forced raw injection
        wr(1, 2, 15'h0021);
        check_all("R7 force disabled");
        chk("R7 no irq", irq_o, 2'b00);
        wr(1, 0, 15'h0020);
        check_all("R7 force enabled");
        chk("R7 irq line1", irq_o, 2'b10);
        wr(0, 0, 15'h7fff);
        wr(0, 2, 15'h0000);
        check_all("R11 zero force");
        wr(1, 3, 15'h0021);
        check_all("R6 R7 cleared");

        // R12 event and clear same cycle
        fire(7);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 3'b011; reg_wdata = 15'h0080;
        evt_strobe = 13'h0080;
        @(negedge clk);
        reg_wr_en = 1'b0; reg_wdata = '0; evt_strobe = '0;
        rd(0, 2, v);
        chk("R12 set wins", v, 15'h0080);
        chk("R12 irq", irq_o, 2'b01);

        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int l = 0; l < 2; l++) begin m_en[l] = '0; m_raw[l] = '0; end
        check_all("R1 re-reset");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule